// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block produces one timed output pulse from three trigger inputs. All three are asynchronous. They are synchronized to the system clock, and their edges are found in the clock domain. The pulse is counted in clock cycles, so its length comes from a width word rather than from an external timing network.

There are three ways to start the pulse. A falling edge on the active-low trigger starts it. A rising edge on the active-high trigger starts it. A rising edge on the active-low clear input also starts it, when the other two inputs are at their enabling levels. Each edge counts only while the other two inputs sit at their enabling levels.

A valid trigger that arrives during a pulse reloads the count, so constant retriggering can hold the output high without end. Holding the clear input low ends any pulse at once and blocks all triggers. One instance covers one channel; instantiate it again for more channels.

Top module: `oneshot_retrig`

## Requirements
- R1: A falling edge on `trig_fall_n` starts a pulse only while `trig_rise` is 1 and `clear_n` is 1.
- R2: A rising edge on `trig_rise` starts a pulse only while `trig_fall_n` is 0 and `clear_n` is 1.
- R3: A rising edge on `clear_n` starts a pulse only while `trig_fall_n` is 0 and `trig_rise` is 1.
- R4: `pulse` is low from the second clock edge after `clear_n` goes low. Any running pulse is cancelled. No trigger has any effect while `clear_n` stays low.
- R5: Suppose an input change made at a falling clock edge is a valid trigger. Then `pulse` is high from the third following rising edge, for exactly `width` clock cycles. The value of `width` is sampled only when the trigger is accepted.
- R6: A trigger accepted while `width` is 0 produces no pulse.
- R7: A valid trigger during a pulse reloads the count. The output stays high continuously until `width` cycles after the latest trigger.
- R8: An edge that occurs while the other inputs are not at their enabling levels starts no pulse. A pulse that is already running still completes its full width.
- R9: `pulse_n` is always the complement of `pulse`.
- R10: The synchronous reset `rst` drives `pulse` low on the next clock edge and clears the count, whatever the level of `clear_n`.
- R11: Static input levels never start a pulse. When the inputs have been stable over the synchronizer window and `pulse` was low, `pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_n | input | 1 | Asynchronous trigger; acts on its falling edge |
| trig_rise | input | 1 | Asynchronous trigger; acts on its rising edge |
| clear_n | input | 1 | Asynchronous clear, active low; acts as a trigger on its rising edge |
| width | input | WIDTH_BITS | Pulse length in clock cycles, sampled when a trigger is accepted |
| pulse | output | 1 | One-shot output, active high |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The fault to look for is a wrong count or wrong edge history. At the ports it shows up as a pulse that starts a cycle early or late, or ends a cycle off its width, or as a pulse that appears after a change that should not have fired. Stale or spurious edge state in the synchronizers shows up within three cycles of the input change. A count that is not reloaded, or not cleared, shows up at the end of the pulse: the falling edge of `pulse` moves by the amount of the error. Each directed case therefore samples every cycle of the window, not just the end state.

// File: rtl/oneshot_retrig.sv
module oneshot_retrig #(
  parameter int WIDTH_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig_fall_n,
  input  logic                  trig_rise,
  input  logic                  clear_n,
  input  logic [WIDTH_BITS-1:0] width,
  output logic                  pulse,
  output logic                  pulse_n
);

  // pipe[0]: first sync flop, pipe[1]: synchronized level, pipe[2]: previous level
  logic [2:0] a_pipe, b_pipe, c_pipe;
  logic [WIDTH_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_pipe <= 3'b111;
      b_pipe <= 3'b000;
      c_pipe <= 3'b111;
    end else begin
      a_pipe <= {a_pipe[1:0], trig_fall_n};
      b_pipe <= {b_pipe[1:0], trig_rise};
      c_pipe <= {c_pipe[1:0], clear_n};
    end
  end

  logic a_lv, b_lv, c_lv;
  assign a_lv = a_pipe[1];
  assign b_lv = b_pipe[1];
  assign c_lv = c_pipe[1];

  logic fire_a, fire_b, fire_c, fire;
  assign fire_a = a_pipe[2] & ~a_lv & b_lv & c_lv;
  assign fire_b = ~b_pipe[2] & b_lv & ~a_lv & c_lv;
  assign fire_c = ~c_pipe[2] & c_lv & ~a_lv & b_lv;
  assign fire   = fire_a | fire_b | fire_c;

  always_ff @(posedge clk) begin
    if (rst || !c_lv)
      cnt <= '0;
    else if (fire)
      cnt <= width;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign pulse   = (cnt != '0) & c_lv;
  assign pulse_n = ~pulse;

endmodule

// File: rtl/oneshot_retrig_chk.sv
module oneshot_retrig_chk (
  input logic clk,
  input logic rst,
  input logic trig_fall_n,
  input logic trig_rise,
  input logic clear_n,
  input logic pulse,
  input logic pulse_n
);

  // R4
  clear_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clear_n, 2) |-> !pulse);

  // R4
  rise_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(clear_n, 2));

  // R10
  reset_low_chk: assert property (@(posedge clk) rst |=> !pulse);

  // R11
  no_edge_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(pulse) &&
     $past(trig_fall_n, 3) == $past(trig_fall_n, 4) &&
     $past(trig_rise, 3)   == $past(trig_rise, 4) &&
     $past(clear_n, 3)     == $past(clear_n, 4)) |-> !pulse);

  // R9
  always @(negedge clk) begin
    if (!rst) complement_chk: assert (pulse_n == !pulse);
  end

endmodule

bind oneshot_retrig oneshot_retrig_chk u_chk (.*);

// File: tb/oneshot_retrig_tb.sv
module oneshot_retrig_tb;

  logic clk = 0;
  logic rst = 1;
  logic a = 1, b = 0, c = 1;
  logic [15:0] width = 0;
  logic pulse, pulse_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  oneshot_retrig u_dut (
    .clk(clk), .rst(rst), .trig_fall_n(a), .trig_rise(b), .clear_n(c),
    .width(width), .pulse(pulse), .pulse_n(pulse_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // samples the window after an edge driven at the current negedge
  task automatic measure(input string tag, input int win, input int exp_first, input int exp_len);
    int first = 0, len = 0, bad = 0;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (pulse_n !== ~pulse) bad++;
      if (pulse === 1'b1) begin
        len++;
        if (first == 0) first = i;
      end
    end
    check({tag, " start"}, first, exp_first);
    check({tag, " length"}, len, exp_len);
    check("R9 complement", bad, 0);
  endtask

  task automatic t_reset;
    check("R10 pulse after reset", pulse, 0);
    check("R9 pulse_n after reset", pulse_n, 1);
    rst = 0;
    settle(2);
    b = 1;
    settle(6);
    check("R8 B rise with A high", pulse, 0);
  endtask

  task automatic t_fall_a;
    width = 5;
    a = 0;
    fork
      measure("R1 A fall", 14, 3, 5);
      begin settle(4); width = 9; end
    join
    a = 1;
    settle(6);
    check("R5 width sampled at trigger", pulse, 0);
  endtask

  task automatic t_rise_b;
    width = 7;
    b = 0;
    settle(6);
    a = 0;
    settle(6);
    check("R8 A fall with B low", pulse, 0);
    b = 1;
    measure("R2 B rise", 16, 3, 7);
  endtask

  task automatic t_clear_trig;
    width = 4;
    c = 0;
    settle(6);
    check("R4 low while clear low", pulse, 0);
    c = 1;
    measure("R3 clear rise", 12, 3, 4);
  endtask

  task automatic t_cancel;
    int hi = 0;
    a = 1;
    settle(6);
    width = 20;
    a = 0;
    settle(6);
    check("R1 pulse running", pulse, 1);
    c = 0;
    settle(1);
    check("R4 one edge after clear", pulse, 1);
    settle(1);
    check("R4 cancelled", pulse, 0);
    a = 1; settle(4); a = 0; b = 0; settle(4); b = 1; settle(6);
    check("R4 triggers inhibited", pulse, 0);
    a = 1;
    settle(4);
    c = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pulse) hi++;
    end
    check("R4 clear rise with A high", hi, 0);
  endtask

  task automatic t_zero;
    width = 0;
    a = 0;
    measure("R6 zero width", 10, 0, 0);
    a = 1;
    settle(6);
  endtask

  task automatic t_retrig;
    int first = 0, len = 0;
    width = 10;
    a = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (pulse) begin
        len++;
        if (first == 0) first = i;
      end
      if (i == 5) a = 1;
      if (i == 6) a = 0;
    end
    check("R7 retrigger start", first, 3);
    check("R7 retrigger length", len, 16);
  endtask

  task automatic t_sync_reset;
    a = 1;
    settle(6);
    width = 30;
    a = 0;
    settle(5);
    check("R1 pulse before reset", pulse, 1);
    a = 1;
    rst = 1;
    settle(1);
    check("R10 reset mid pulse", pulse, 0);
    rst = 0;
    measure("R10 no pulse after reset", 10, 0, 0);
  endtask

  task automatic t_static;
    int hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pulse) hi++;
    end
    check("R11 static inputs", hi, 0);
  endtask

  initial begin
    settle(4);
    t_reset();
    t_fall_a();
    t_rise_b();
    t_clear_trig();
    t_cancel();
    t_zero();
    t_retrig();
    t_sync_reset();
    t_static();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule